// File: doc/BRIEF.md
# Maskable Vectored Interrupt Encoder

This block gathers eight active-low interrupt request lines, filters them through an 8-bit mask that software loads with an I/O write, and raises a single interrupt request toward the processor while any line that is still allowed through is low. A request line whose mask bit is 1 is removed before priority is resolved, so it can neither raise the request nor win the vector.

When the processor acknowledges, the block latches the number of the highest-priority pending line and drives a one-byte restart opcode on its vector output for as long as the acknowledge lasts. The opcode sends the processor to one of eight entry points spaced eight bytes apart, starting at address zero. A global enable input switches the whole vector path off. While it is off, the request lines are ignored and an acknowledge gets no answer.

Top module: `vec_irq_encoder`

## Requirements
- R1: Reset clears every mask bit, so after reset any low request line raises `irq` while `vec_en` is 1.
- R2: While `vec_en` is 1, `irq` is high exactly when at least one request line is low and its mask bit is 0. It is a combinational function of the lines and the mask register.
- R3: A cycle with `io_wr` high and `io_addr` equal to 0xFE loads `io_wdata` into the mask at that clock edge. Mask bit n set to 1 blocks line n, and bit n set to 0 lets it through.
- R4: An I/O write to any address other than 0xFE leaves the mask unchanged.
- R5: Among the unmasked low lines, the highest-numbered one wins. Line 7 has the highest priority and line 0 the lowest.
- R6: The vector byte is 0xC7 with the winning line number n in bits 5:3, giving 0xC7, 0xCF, 0xD7, 0xDF, 0xE7, 0xEF, 0xF7 and 0xFF for n = 0 to 7. This sends the processor to address 8*n.
- R7: The line number is captured at the first clock edge that sees `ack` high. The vector byte then stays constant until the acknowledge ends, even if request lines or the mask change in the meantime.
- R8: `vec_oe` rises after the first edge that sees `ack` high and falls after the first edge that sees `ack` low. `vec_data` is 0x00 whenever `vec_oe` is low.
- R9: While `vec_en` is 0, `irq` stays low for any request pattern. An acknowledge that starts while `vec_en` is 0 leaves `vec_oe` low.
- R10: A masked line never decides the vector, even when it outranks the unmasked lines that are also low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | 8 | Interrupt request lines, active low; bit n is line n |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O port address of the write |
| io_wdata | input | 8 | I/O write data |
| ack | input | 1 | Interrupt acknowledge cycle in progress |
| vec_en | input | 1 | Global enable of the vector path |
| irq | output | 1 | Interrupt request to the processor |
| vec_data | output | 8 | Restart opcode, zero when not driven |
| vec_oe | output | 1 | Vector byte is valid and should be driven |

## Verification
The hardest case to reach is a change of the pending set while an acknowledge is open. A higher-priority line going low, or a mask write, in the middle of the acknowledge must not disturb the byte already on the output. To reach it, the stimulus opens an acknowledge on a low-priority line, then pulls line 7 low and writes a new mask while `ack` is held, and checks the vector byte on every cycle. It also checks that a masked line 7 loses to a lower unmasked line, and that an acknowledge given while the block is disabled produces no output.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
    localparam int unsigned LINES_DEF    = 8;
    localparam int unsigned AW_DEF       = 8;
    localparam int unsigned DW_DEF       = 8;
    localparam logic [7:0]  MASK_PORT_DEF = 8'hFE;
    localparam logic [7:0]  OPC_BASE_DEF  = 8'hC7;
    localparam int unsigned VEC_LSB_DEF  = 3;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_DRIVE = 1'b1
    } vec_phase_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned LINES     = 8,
    parameter int unsigned AW        = 8,
    parameter logic [AW-1:0] PORT_ADDR = 8'hFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [AW-1:0]    io_addr,
    input  logic [LINES-1:0] io_wdata,
    output logic [LINES-1:0] mask_q
);
    typedef struct packed {
        logic [LINES-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (io_wr && (io_addr == PORT_ADDR)) begin
            st_d.mask = io_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IDXW = $clog2(LINES)
) (
    input  logic [LINES-1:0] req_n,
    input  logic [LINES-1:0] mask,
    input  logic             vec_en,
    output logic             any,
    output logic [IDXW-1:0]  num
);
    logic [LINES-1:0] live;

    for (genvar g = 0; g < LINES; g++) begin : g_gate
        assign live[g] = vec_en & ~req_n[g] & ~mask[g];
    end

    always_comb begin
        num = '0;
        for (int i = 0; i < LINES; i++) begin
            if (live[i]) begin
                num = IDXW'(i);
            end
        end
    end

    assign any = |live;
endmodule

// File: rtl/irq_vec_hold.sv
module irq_vec_hold
    import vec_irq_pkg::*;
#(
    parameter int unsigned LINES    = 8,
    parameter int unsigned DW       = 8,
    parameter logic [DW-1:0] OPC_BASE = 8'hC7,
    parameter int unsigned VEC_LSB  = 3,
    localparam int unsigned IDXW    = $clog2(LINES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack,
    input  logic            vec_en,
    input  logic [IDXW-1:0] enc_num,
    output logic            vec_oe,
    output logic [DW-1:0]   vec_data
);
    typedef struct packed {
        logic            ack_seen;
        vec_phase_e      phase;
        logic [IDXW-1:0] num;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        ack_start;

    always_comb begin
        st_d          = st_q;
        ack_start     = ack & ~st_q.ack_seen;
        st_d.ack_seen = ack;
        if (ack_start) begin
            st_d.phase = vec_en ? PH_DRIVE : PH_IDLE;
            st_d.num   = enc_num;
        end else if (!ack) begin
            st_d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ack_seen: 1'b0, phase: PH_IDLE, num: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_oe   = (st_q.phase == PH_DRIVE);
    assign vec_data = vec_oe ? (OPC_BASE | (DW'(st_q.num) << VEC_LSB)) : '0;
endmodule

// File: rtl/vec_irq_encoder.sv
module vec_irq_encoder
    import vec_irq_pkg::*;
#(
    parameter int unsigned LINES     = LINES_DEF,
    parameter int unsigned AW        = AW_DEF,
    parameter int unsigned DW        = DW_DEF,
    parameter logic [AW-1:0] MASK_PORT = MASK_PORT_DEF,
    parameter logic [DW-1:0] OPC_BASE  = OPC_BASE_DEF,
    parameter int unsigned VEC_LSB   = VEC_LSB_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_n,
    input  logic             io_wr,
    input  logic [AW-1:0]    io_addr,
    input  logic [LINES-1:0] io_wdata,
    input  logic             ack,
    input  logic             vec_en,
    output logic             irq,
    output logic [DW-1:0]    vec_data,
    output logic             vec_oe
);
    localparam int unsigned IDXW = $clog2(LINES);

    logic [LINES-1:0] mask_q;
    logic [IDXW-1:0]  enc_num;

    irq_mask_reg #(
        .LINES    (LINES),
        .AW       (AW),
        .PORT_ADDR(MASK_PORT)
    ) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .mask_q  (mask_q)
    );

    irq_prio_enc #(
        .LINES(LINES)
    ) i_enc (
        .req_n (req_n),
        .mask  (mask_q),
        .vec_en(vec_en),
        .any   (irq),
        .num   (enc_num)
    );

    irq_vec_hold #(
        .LINES   (LINES),
        .DW      (DW),
        .OPC_BASE(OPC_BASE),
        .VEC_LSB (VEC_LSB)
    ) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ack),
        .vec_en  (vec_en),
        .enc_num (enc_num),
        .vec_oe  (vec_oe),
        .vec_data(vec_data)
    );
endmodule

// File: rtl/vec_irq_encoder_chk.sv
module vec_irq_encoder_chk #(
    parameter int unsigned LINES     = 8,
    parameter int unsigned AW        = 8,
    parameter int unsigned DW        = 8,
    parameter logic [AW-1:0] MASK_PORT = 8'hFE
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] req_n,
    input logic             io_wr,
    input logic [AW-1:0]    io_addr,
    input logic [LINES-1:0] io_wdata,
    input logic             ack,
    input logic             vec_en,
    input logic             irq,
    input logic [DW-1:0]    vec_data,
    input logic             vec_oe,
    input logic [LINES-1:0] mask_q
);
    p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == MASK_PORT) |=> (mask_q == $past(io_wdata)));

    p_mask_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(io_wr && io_addr == MASK_PORT)) |=> $stable(mask_q));

    p_blocked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&(req_n | mask_q)) |-> !irq);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_en |-> !irq);

    p_opcode_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (vec_data[2:0] == 3'b111 && vec_data[7:6] == 2'b11));

    p_vec_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && $past(vec_oe)) |-> $stable(vec_data));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_data == '0));

    p_oe_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack) && vec_en) |=> vec_oe);

    p_oe_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_oe);
endmodule

bind vec_irq_encoder vec_irq_encoder_chk #(
    .LINES    (LINES),
    .AW       (AW),
    .DW       (DW),
    .MASK_PORT(MASK_PORT)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n   (req_n),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .io_wdata(io_wdata),
    .ack     (ack),
    .vec_en  (vec_en),
    .irq     (irq),
    .vec_data(vec_data),
    .vec_oe  (vec_oe),
    .mask_q  (mask_q)
);

// File: tb/test_vec_irq_encoder.sv
module test_vec_irq_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // entry: {mask[25:18], req_n[17:10], en[9], exp_irq[8], exp_vec[7:0]}
    localparam logic [25:0] VECS [NVEC] = '{
        {8'h00, 8'hFE, 1'b1, 1'b1, 8'hC7},  // R6 line0 alone
        {8'h00, 8'h7F, 1'b1, 1'b1, 8'hFF},  // R6 line7 alone
        {8'h00, 8'h00, 1'b1, 1'b1, 8'hFF},  // R5 all low
        {8'h80, 8'h00, 1'b1, 1'b1, 8'hF7},  // R10 line7 masked
        {8'hFF, 8'h00, 1'b1, 1'b0, 8'h00},  // R2 all masked
        {8'h0F, 8'hF5, 1'b1, 1'b0, 8'h00},  // R2 only masked lines low
        {8'h0F, 8'hE5, 1'b1, 1'b1, 8'hE7},  // R10 line4 over masked 3,1
        {8'h00, 8'hDB, 1'b1, 1'b1, 8'hEF},  // R5 lines 5 and 2
        {8'h00, 8'h00, 1'b0, 1'b0, 8'h00},  // R9 disabled
        {8'h01, 8'hF7, 1'b1, 1'b1, 8'hDF}   // R3 line3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_n = 8'hFF;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic       ack = 1'b0;
    logic       vec_en = 1'b1;
    logic       irq;
    logic [7:0] vec_data;
    logic       vec_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vec_irq_encoder i_vec_irq_encoder (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (req_n),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .ack     (ack),
        .vec_en  (vec_en),
        .irq     (irq),
        .vec_data(vec_data),
        .vec_oe  (vec_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_addr = addr; io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // opens an acknowledge; returns after the capturing edge
    task automatic ack_open();
        @(negedge clk);
        ack = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic ack_close();
        @(negedge clk);
        ack = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state
        check("R8 reset oe", {7'd0, vec_oe}, 8'h00);
        check("R8 reset data", vec_data, 8'h00);
        check("R2 idle irq", {7'd0, irq}, 8'h00);
        req_n = 8'hFE; #1;
        check("R1 mask clear after reset", {7'd0, irq}, 8'h01);
        req_n = 8'hFF;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            io_write(8'hFE, VECS[i][25:18]);
            req_n  = VECS[i][17:10];
            vec_en = VECS[i][9];
            #1;
            check($sformatf("R2 irq entry %0d", i), {7'd0, irq}, {7'd0, VECS[i][8]});
            if (VECS[i][8]) begin
                ack_open();
                check($sformatf("R6 vector entry %0d", i), vec_data, VECS[i][7:0]);
                check($sformatf("R8 oe entry %0d", i), {7'd0, vec_oe}, 8'h01);
                ack_close();
                check($sformatf("R8 oe drop entry %0d", i), {7'd0, vec_oe}, 8'h00);
                check($sformatf("R8 data zero entry %0d", i), vec_data, 8'h00);
            end
            req_n = 8'hFF; vec_en = 1'b1;
        end

        // R4: write to another port leaves mask (0x01 from last entry) intact
        io_write(8'hFD, 8'hFF);
        req_n = 8'hFE; #1;
        check("R4 foreign port ignored, line0 still blocked", {7'd0, irq}, 8'h00);
        req_n = 8'hFB; #1;
        check("R4 foreign port ignored, line2 open", {7'd0, irq}, 8'h01);

        // R7: hold while higher line arrives and mask changes
        ack_open();
        check("R7 captured line2", vec_data, 8'hD7);
        @(negedge clk);
        req_n = 8'h7B;
        @(posedge clk); #1;
        check("R7 stable after line7 low", vec_data, 8'hD7);
        io_write(8'hFE, 8'h04);
        @(posedge clk); #1;
        check("R7 stable after mask write", vec_data, 8'hD7);
        check("R7 oe still high", {7'd0, vec_oe}, 8'h01);
        ack_close();
        check("R8 oe released", {7'd0, vec_oe}, 8'h00);
        ack_open();
        check("R5 new ack picks line7", vec_data, 8'hFF);
        ack_close();

        // R9: acknowledge while disabled
        @(negedge clk);
        vec_en = 1'b0; req_n = 8'h00; #1;
        check("R9 irq low when disabled", {7'd0, irq}, 8'h00);
        ack_open();
        check("R9 no oe when disabled", {7'd0, vec_oe}, 8'h00);
        check("R9 no data when disabled", vec_data, 8'h00);
        ack_close();
        vec_en = 1'b1;

        // R1: reset clears a full mask
        io_write(8'hFE, 8'hFF);
        #1;
        check("R3 full mask blocks", {7'd0, irq}, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 reset reopens lines", {7'd0, irq}, 8'h01);
        ack_open();
        check("R1 vector after reset", vec_data, 8'hFF);
        ack_close();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule